// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Generator

This block supplies the parity logic for one side of a 36-bit data port. The port is divided into four nine-bit lanes. The top bit of each lane is that lane's parity bit, and the lower eight bits carry data. Incoming bus words are checked lane by lane against odd or even parity, as chosen by one global sense input. If any lane fails, an active-low error flag goes low. The check is purely advisory: it never stalls or blocks a transfer.

The same four parity trees also generate parity for mailbox read data. When the port performs a selected mailbox read with generation enabled, the trees are switched from the input bus to the read word. The top bit of each read lane is then replaced with freshly computed parity. Because the trees are busy generating, the error flag is held inactive for the whole of that access. All logic is combinational and holds no state.

Top module: `prt_lane_parity`

## Requirements
- R1: Lane k occupies bus bits 9k to 9k+8 (k = 0..3). Bit 9k+8 is that lane's parity bit, and bits 9k to 9k+7 are its data.
- R2: With `odd_sel_i` = 0 (even sense), a lane fails when the XOR of its nine bits is 1.
- R3: With `odd_sel_i` = 1 (odd sense), a lane fails when the XOR of its nine bits is 0.
- R4: Outside generation mode, `perr_n_o` is 0 when one or more lanes fail and 1 when all four lanes pass, for every combination of failing lanes.
- R5: Generation mode is active exactly when `cs_n_i`=0, `en_i`=1, `wr_i`=0, `mbx_i`=1 and `gen_en_i`=1. In that mode `perr_n_o` is 1 whatever `chk_bus_i` holds.
- R6: In generation mode, bit 9k+8 of `rd_data_o` is the XOR of bits 9k to 9k+7 of `rd_data_i`, inverted when `odd_sel_i` = 1. Each output lane therefore has the selected parity.
- R7: Outside generation mode, `rd_data_o` equals `rd_data_i` on all 36 bits, including the parity bits. This holds when any single mode condition is missing.
- R8: The eight data bits of every lane of `rd_data_o` always equal those of `rd_data_i`. Parity results never alter data.
- R9: Both outputs follow their inputs combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| chk_bus_i | input | 36 | Word presented on the port bus, checked for parity |
| odd_sel_i | input | 1 | Parity sense: 1 odd, 0 even |
| cs_n_i | input | 1 | Active-low port select |
| en_i | input | 1 | Port transfer enable |
| wr_i | input | 1 | Direction: 1 write, 0 read |
| mbx_i | input | 1 | Mailbox register selected |
| gen_en_i | input | 1 | Parity generation enable for reads |
| rd_data_i | input | 36 | Mailbox word being read out |
| rd_data_o | output | 36 | Read word, with regenerated parity bits in generation mode |
| perr_n_o | output | 1 | Active-low parity error, any lane |

## Verification
For every lane and both senses, one lane is swept through all 512 nine-bit values while the other lanes hold valid words. This separates even from odd sense and exposes a wrong lane boundary or a misplaced parity bit. All sixteen failing-lane masks are applied to show that the flag is an OR over lanes. All 32 control combinations are then crossed with pseudo-random words that carry a deliberately bad lane. Only the single generation combination may suppress the error and rewrite parity. Every other combination must keep checking and pass read data through unchanged. One further check samples the outputs between clock edges to confirm that they do not wait for a clock.

// File: rtl/prt_pkg.sv
package prt_pkg;
   typedef enum logic {
      PRT_EVEN = 1'b0,
      PRT_ODD  = 1'b1
   } prt_sense_e;

   typedef struct packed {
      logic cs_n;
      logic en;
      logic wr;
      logic mbx;
      logic gen_en;
   } prt_ctl_t;
endpackage

// File: rtl/prt_lane_tree.sv
module prt_lane_tree #(
   parameter int DATA_BITS = 8
) (
   input  logic [DATA_BITS-1:0] d_i,
   output logic                 p_o
);
   localparam int HALF = DATA_BITS / 2;

   generate
      if (DATA_BITS < 1) begin : g_bad
         $error("prt_lane_tree: DATA_BITS must be at least 1");
      end
      if (DATA_BITS >= 4 && (DATA_BITS % 2) == 0) begin : g_split
         logic lo_p, hi_p;
         assign lo_p = ^d_i[HALF-1:0];
         assign hi_p = ^d_i[DATA_BITS-1:HALF];
         assign p_o  = lo_p ^ hi_p;
      end else begin : g_flat
         assign p_o = ^d_i;
      end
   endgenerate
endmodule

// File: rtl/prt_mode_dec.sv
module prt_mode_dec
   import prt_pkg::*;
(
   input  prt_ctl_t ctl_i,
   output logic     gen_act_o
);
   always_comb begin
      gen_act_o = !ctl_i.cs_n && ctl_i.en && !ctl_i.wr && ctl_i.mbx && ctl_i.gen_en;
   end
endmodule

// File: rtl/prt_lane_slice.sv
module prt_lane_slice #(
   parameter int DATA_BITS = 8,
   parameter bit GEN_PRESENT = 1'b1,
   localparam int LANE_W = DATA_BITS + 1
) (
   input  logic [LANE_W-1:0] chk_lane_i,
   input  logic [LANE_W-1:0] rd_lane_i,
   input  logic              gen_act_i,
   input  logic              odd_i,
   output logic              fail_o,
   output logic [LANE_W-1:0] rd_lane_o
);
   logic [DATA_BITS-1:0] tree_in;
   logic                 tree_p;

   // one tree per lane, fed from the bus or from the read word
   assign tree_in = gen_act_i ? rd_lane_i[DATA_BITS-1:0] : chk_lane_i[DATA_BITS-1:0];

   prt_lane_tree #(.DATA_BITS(DATA_BITS)) tree_i (
      .d_i (tree_in),
      .p_o (tree_p)
   );

   assign fail_o = !gen_act_i && (tree_p ^ chk_lane_i[DATA_BITS] ^ odd_i);

   generate
      if (GEN_PRESENT) begin : g_gen
         assign rd_lane_o = gen_act_i ? {tree_p ^ odd_i, rd_lane_i[DATA_BITS-1:0]}
                                      : rd_lane_i;
      end else begin : g_pass
         assign rd_lane_o = rd_lane_i;
      end
   endgenerate
endmodule

// File: rtl/prt_lane_parity.sv
module prt_lane_parity
   import prt_pkg::*;
#(
   parameter int LANES       = 4,
   parameter int DATA_BITS   = 8,
   parameter bit GEN_PRESENT = 1'b1,
   localparam int LANE_W = DATA_BITS + 1,
   localparam int BUS_W  = LANES * LANE_W
) (
   input  logic [BUS_W-1:0] chk_bus_i,
   input  logic             odd_sel_i,
   input  logic             cs_n_i,
   input  logic             en_i,
   input  logic             wr_i,
   input  logic             mbx_i,
   input  logic             gen_en_i,
   input  logic [BUS_W-1:0] rd_data_i,
   output logic [BUS_W-1:0] rd_data_o,
   output logic             perr_n_o
);
   prt_ctl_t   ctl;
   prt_sense_e sense;
   logic       gen_dec;
   logic       gen_act;
   logic [LANES-1:0] lane_fail;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("prt_lane_parity: LANES must be at least 1");
      end
   endgenerate

   assign ctl   = '{cs_n: cs_n_i, en: en_i, wr: wr_i, mbx: mbx_i, gen_en: gen_en_i};
   assign sense = prt_sense_e'(odd_sel_i);

   prt_mode_dec dec_i (
      .ctl_i     (ctl),
      .gen_act_o (gen_dec)
   );

   assign gen_act = gen_dec & GEN_PRESENT;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         prt_lane_slice #(.DATA_BITS(DATA_BITS), .GEN_PRESENT(GEN_PRESENT)) slice_i (
            .chk_lane_i (chk_bus_i[k*LANE_W +: LANE_W]),
            .rd_lane_i  (rd_data_i[k*LANE_W +: LANE_W]),
            .gen_act_i  (gen_act),
            .odd_i      (sense == PRT_ODD),
            .fail_o     (lane_fail[k]),
            .rd_lane_o  (rd_data_o[k*LANE_W +: LANE_W])
         );
      end
   endgenerate

   assign perr_n_o = ~|lane_fail;
endmodule

// File: rtl/prt_lane_parity_chk.sv
module prt_lane_parity_chk #(
   parameter int LANES       = 4,
   parameter int DATA_BITS   = 8,
   parameter bit GEN_PRESENT = 1'b1,
   localparam int LANE_W = DATA_BITS + 1,
   localparam int BUS_W  = LANES * LANE_W
) (
   input logic [BUS_W-1:0] chk_bus_i,
   input logic             odd_sel_i,
   input logic             cs_n_i,
   input logic             en_i,
   input logic             wr_i,
   input logic             mbx_i,
   input logic             gen_en_i,
   input logic [BUS_W-1:0] rd_data_i,
   input logic [BUS_W-1:0] rd_data_o,
   input logic             perr_n_o
);
   logic in_gen;
   assign in_gen = GEN_PRESENT && (cs_n_i == 1'b0) && (en_i == 1'b1) &&
                   (wr_i == 1'b0) && (mbx_i == 1'b1) && (gen_en_i == 1'b1);

   always_comb begin
      if (!$isunknown({chk_bus_i, odd_sel_i, cs_n_i, en_i, wr_i, mbx_i, gen_en_i,
                       rd_data_i, rd_data_o, perr_n_o})) begin
         // R5: generation suppresses the error flag
         if (in_gen) begin
            a_r5_gen_flag_high : assert (perr_n_o == 1'b1)
               else $error("R5 flag low during generation");
         end
         // R7: no generation means untouched read data
         if (!in_gen) begin
            a_r7_read_passthru : assert (rd_data_o == rd_data_i)
               else $error("R7 read data altered");
         end
         for (int k = 0; k < LANES; k++) begin
            // R8: data bits of every lane pass through
            a_r8_data_kept : assert (rd_data_o[k*LANE_W +: DATA_BITS] ==
                                     rd_data_i[k*LANE_W +: DATA_BITS])
               else $error("R8 data bits altered in lane %0d", k);
            // R6: generated lanes carry the selected parity
            if (in_gen) begin
               a_r6_gen_lane_sense : assert ((^rd_data_o[k*LANE_W +: LANE_W]) == odd_sel_i)
                  else $error("R6 lane %0d wrong generated parity", k);
            end
            // R4: any lane with the wrong full-lane parity pulls the flag low
            if (!in_gen && ((^chk_bus_i[k*LANE_W +: LANE_W]) != odd_sel_i)) begin
               a_r4_lane_fail_low : assert (perr_n_o == 1'b0)
                  else $error("R4 lane %0d bad but flag high", k);
            end
         end
      end
   end
endmodule

bind prt_lane_parity prt_lane_parity_chk #(
   .LANES(LANES), .DATA_BITS(DATA_BITS), .GEN_PRESENT(GEN_PRESENT)
) chk_i (
   .chk_bus_i (chk_bus_i),
   .odd_sel_i (odd_sel_i),
   .cs_n_i    (cs_n_i),
   .en_i      (en_i),
   .wr_i      (wr_i),
   .mbx_i     (mbx_i),
   .gen_en_i  (gen_en_i),
   .rd_data_i (rd_data_i),
   .rd_data_o (rd_data_o),
   .perr_n_o  (perr_n_o)
);

// File: tb/prt_lane_parity_tb_top.sv
module prt_lane_parity_tb_top;
   localparam int NL = 4;
   localparam int LW = 9;
   localparam int BW = NL * LW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [BW-1:0] chk_bus, rd_in, rd_out;
   logic odd, cs_n, en, wr, mbx, gen_en, perr_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   prt_lane_parity dut_i (
      .chk_bus_i (chk_bus),
      .odd_sel_i (odd),
      .cs_n_i    (cs_n),
      .en_i      (en),
      .wr_i      (wr),
      .mbx_i     (mbx),
      .gen_en_i  (gen_en),
      .rd_data_i (rd_in),
      .rd_data_o (rd_out),
      .perr_n_o  (perr_n)
   );

   function automatic logic exp_flag(input logic [BW-1:0] bus, input logic o);
      logic f = 1'b1;
      for (int k = 0; k < NL; k++) begin
         int ones = 0;
         for (int b = 0; b < LW; b++) ones += int'(bus[k*LW + b]);
         if ((ones % 2) != int'(o)) f = 1'b0;
      end
      return f;
   endfunction

   function automatic logic [BW-1:0] exp_gen(input logic [BW-1:0] w, input logic o);
      logic [BW-1:0] r = w;
      for (int k = 0; k < NL; k++) begin
         int ones = 0;
         for (int b = 0; b < 8; b++) ones += int'(w[k*LW + b]);
         r[k*LW + 8] = ((ones % 2) == 1) ^ o;
      end
      return r;
   endfunction

   function automatic logic [BW-1:0] mix(input logic [BW-1:0] s);
      logic [BW-1:0] x = s;
      x = x ^ (x << 7);
      x = x ^ (x >> 9);
      x = x ^ (x << 4);
      return x ^ 36'h5A3C9E17B;
   endfunction

   // a lane word whose nine bits hold sense o
   function automatic logic [LW-1:0] good_lane(input logic [7:0] d, input logic o);
      return {(^d) ^ o, d};
   endfunction

   task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                        input logic [BW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      chk_bus = '0; rd_in = '0; odd = 1'b0;
      cs_n = 1'b1; en = 1'b0; wr = 1'b0; mbx = 1'b0; gen_en = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset/idle state: zero words pass even parity, no generation
      check(perr_n == 1'b1, "R4 idle flag", BW'(perr_n), BW'(1));
      check(rd_out == '0, "R7 idle read", rd_out, '0);

      // single-lane sweeps, both senses (R1 R2 R3)
      for (int o = 0; o < 2; o++) begin
         for (int ln = 0; ln < NL; ln++) begin
            for (int v = 0; v < 512; v++) begin
               logic [BW-1:0] w;
               @(posedge clk);
               for (int k = 0; k < NL; k++)
                  w[k*LW +: LW] = good_lane(8'(k * 37 + 5), o[0]);
               w[ln*LW +: LW] = 9'(v);
               chk_bus = w; odd = o[0];
               @(negedge clk);
               check(perr_n == exp_flag(w, o[0]), o ? "R3 R1 odd lane sweep" : "R2 R1 even lane sweep",
                     BW'(perr_n), BW'(exp_flag(w, o[0])));
            end
         end
      end

      // every failing-lane mask (R4)
      for (int o = 0; o < 2; o++) begin
         for (int m = 0; m < 16; m++) begin
            logic [BW-1:0] w;
            @(posedge clk);
            for (int k = 0; k < NL; k++) begin
               w[k*LW +: LW] = good_lane(8'(m * 11 + k), o[0]);
               if (m[k]) w[k*LW + 8] = ~w[k*LW + 8];
            end
            chk_bus = w; odd = o[0];
            @(negedge clk);
            check(perr_n == (m == 0), "R4 lane mask", BW'(perr_n), BW'(m == 0));
         end
      end

      // control sweep crossed with data (R5 R6 R7 R8)
      begin
         logic [BW-1:0] seed = 36'h123456789;
         for (int c = 0; c < 32; c++) begin
            for (int o = 0; o < 2; o++) begin
               for (int p = 0; p < 8; p++) begin
                  logic gm;
                  logic [BW-1:0] bad, expd;
                  seed = mix(seed);
                  bad = seed;
                  for (int k = 0; k < NL; k++)
                     bad[k*LW +: LW] = good_lane(seed[k*LW +: 8], o[0]);
                  bad[2*LW + 8] = ~bad[2*LW + 8];
                  @(posedge clk);
                  {cs_n, en, wr, mbx, gen_en} = 5'(c);
                  odd = o[0]; chk_bus = bad; rd_in = mix(seed ^ 36'hF0F0F0F0F);
                  gm = (c == 5'b01011);
                  expd = gm ? exp_gen(rd_in, o[0]) : rd_in;
                  @(negedge clk);
                  if (gm) begin
                     check(perr_n == 1'b1, "R5 flag forced high", BW'(perr_n), BW'(1));
                     check(rd_out == expd, "R6 generated parity", rd_out, expd);
                  end else begin
                     check(perr_n == 1'b0, "R5 checking stays active", BW'(perr_n), BW'(0));
                     check(rd_out == expd, "R7 pass-through", rd_out, expd);
                  end
                  for (int k = 0; k < NL; k++)
                     check(rd_out[k*LW +: 8] == rd_in[k*LW +: 8], "R8 data bits kept",
                           BW'(rd_out[k*LW +: 8]), BW'(rd_in[k*LW +: 8]));
               end
            end
         end
      end

      // combinational response between clock edges (R9)
      @(negedge clk);
      {cs_n, en, wr, mbx, gen_en} = 5'b01011;
      odd = 1'b1; rd_in = 36'h0_0000_0001; chk_bus = 36'h1;
      #2;
      check(perr_n == 1'b1, "R9 flag without clock", BW'(perr_n), BW'(1));
      check(rd_out == exp_gen(rd_in, 1'b1), "R9 read without clock", rd_out, exp_gen(rd_in, 1'b1));
      gen_en = 1'b0;
      #2;
      check(perr_n == exp_flag(chk_bus, 1'b1), "R9 flag after mode drop", BW'(perr_n),
            BW'(exp_flag(chk_bus, 1'b1)));
      check(rd_out == rd_in, "R9 read after mode drop", rd_out, rd_in);

      finish_run();
   end
endmodule